// File: doc/BRIEF.md
# Round-Robin Sensor Scan Status Register

This block watches a small set of home sensors (front door, rear door, fire alarm, window, temperature) by looking at exactly one of them on each clock cycle. It walks through them from the most important to the least important, then spends one extra idle cycle before starting again. A frame is therefore one slot longer than the number of sensors: six cycles with the default of five sensors.

A status register holds a code that a display stage can show. Whenever the sensor examined in the current slot reads high, the status takes that sensor's code on the next clock edge. This happens even if a more important sensor set the status earlier in the same frame, so within a frame the most recent high reading wins. A low reading and the idle slot leave the status unchanged. The current slot number is also brought out, so that a display or a test can tell which sensor is under examination.

Top module: `sensor_scan_status`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next values are `scan_slot` = 0 and `status_code` = 0. This holds whether the reset arrives at start-up or in the middle of a frame.
- R2: Out of reset, `scan_slot` goes up by one on each rising edge while it is below the last slot, which is NUM_SENSORS (5 by default).
- R3: After the last slot, which is the idle slot, `scan_slot` returns to 0, the front-door slot. A frame therefore lasts NUM_SENSORS+1 cycles.
- R4: Slot k, for k from 0 to NUM_SENSORS-1, examines `sensors[k]`. Bit 0 is the front door, bit 1 the rear door, bit 2 the fire alarm, bit 3 the window and bit 4 the temperature. If that bit is high at the edge, `status_code` becomes k+1 (1 front, 2 rear, 3 fire, 4 window, 5 temperature). This replaces any code written earlier in the frame, including a higher-priority one.
- R5: If the bit examined in a sensor slot is low, `status_code` keeps its value.
- R6: In the idle slot (`scan_slot` = NUM_SENSORS) no sensor is examined, and `status_code` keeps its value whatever `sensors` carries.
- R7: Bits of `sensors` other than the one examined in the current slot have no effect on `status_code`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| sensors | input | NUM_SENSORS | Sensor levels, with bit 0 the highest priority (front door) |
| scan_slot | output | $clog2(NUM_SENSORS+1) | Slot examined in this cycle; the value NUM_SENSORS marks the idle slot |
| status_code | output | $clog2(NUM_SENSORS+1) | Code of the last sensor found high; 0 means idle |

## Verification
A slot counter that skips a value, repeats a value or wraps at the wrong point shows up on `scan_slot` at the very next edge. From then on it also pairs the wrong bit of `sensors` with the wrong code, so `status_code` goes wrong on the first high reading that follows. A status register that ignores the idle slot, that keeps the older higher-priority code, or that reacts to a bit not under examination differs from the expected code one cycle after that stimulus. Random sensor patterns reach every slot many times per run. Directed frames cover all sensors high, a front-door reading overwritten by a later one in the same frame, and a reset in the middle of a frame.

// File: rtl/scan_status_pkg.sv
// Package: scan_status_pkg
// Holds the shared defaults and a width helper for the sensor scan block.
// It assumes that the sensor index order is also the priority order, with
// index 0 the most important sensor.
package scan_status_pkg;
    // Default number of sensors scanned per frame
    localparam int unsigned DEF_NUM_SENSORS = 5;

    // Bits needed to hold the values 0..n
    function automatic int unsigned span_width(input int unsigned n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction
endpackage

// File: rtl/scan_slot_counter.sv
// Module: scan_slot_counter
// Counts through one frame of slots: one slot for each sensor, then one idle
// slot, then back to slot 0. It assumes a synchronous active-low reset.
module scan_slot_counter #(
    parameter int unsigned NUM_SENSORS = 5,
    localparam int unsigned SLOT_W = scan_status_pkg::span_width(NUM_SENSORS)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [SLOT_W-1:0] slot
);
    localparam logic [SLOT_W-1:0] IDLE_SLOT = SLOT_W'(NUM_SENSORS);

    // Step to the next slot, wrapping after the idle slot
    always_ff @(posedge clk) begin
        if (!rst_n)
            slot <= '0;
        else if (slot == IDLE_SLOT)
            slot <= '0;
        else
            slot <= slot + SLOT_W'(1);
    end

    // R1
    slot_reset_chk: assert property (@(posedge clk) !rst_n |=> (slot == '0));
    // R2
    slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot != IDLE_SLOT) |=> (slot == $past(slot) + SLOT_W'(1)));
    // R3
    slot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == IDLE_SLOT) |=> (slot == '0));
endmodule

// File: rtl/scan_status_reg.sv
// Module: scan_status_reg
// Decodes the current slot into a one-hot match against the sensor bits.
// When the examined bit is high, it loads that sensor's code (index + 1).
// Otherwise the register holds. It assumes that the slot value NUM_SENSORS
// is the idle slot and that no slot larger than that occurs.
module scan_status_reg #(
    parameter int unsigned NUM_SENSORS = 5,
    localparam int unsigned SLOT_W = scan_status_pkg::span_width(NUM_SENSORS),
    localparam int unsigned CODE_W = scan_status_pkg::span_width(NUM_SENSORS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [SLOT_W-1:0]      slot,
    input  logic [NUM_SENSORS-1:0] sensors,
    output logic [CODE_W-1:0]      status
);
    localparam logic [SLOT_W-1:0] IDLE_SLOT = SLOT_W'(NUM_SENSORS);

    logic [NUM_SENSORS-1:0] hit;
    logic [CODE_W-1:0]      hit_code;

    // One match line per sensor: high when it is that sensor's slot and its bit is high
    for (genvar k = 0; k < NUM_SENSORS; k++) begin : g_match
        assign hit[k] = (slot == SLOT_W'(k)) && sensors[k];
    end

    // Turn the one-hot match into a status code
    always_comb begin
        hit_code = '0;
        for (int k = 0; k < NUM_SENSORS; k++)
            if (hit[k]) hit_code = CODE_W'(k + 1);
    end

    // Load on a match, otherwise hold; reset clears the code
    always_ff @(posedge clk) begin
        if (!rst_n)
            status <= '0;
        else if (|hit)
            status <= hit_code;
    end

    // R1
    status_reset_chk: assert property (@(posedge clk) !rst_n |=> (status == '0));
    // R4
    status_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((slot < IDLE_SLOT) && sensors[slot]) |=> (status == CODE_W'($past(slot)) + CODE_W'(1)));
    // R5
    status_hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((slot < IDLE_SLOT) && !sensors[slot]) |=> $stable(status));
    // R6
    status_hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == IDLE_SLOT) |=> $stable(status));
endmodule

// File: rtl/sensor_scan_status.sv
// Module: sensor_scan_status
// Top level of the sensor scan. A slot counter picks one sensor per cycle,
// from the highest priority down, followed by one idle slot. A status register
// keeps the code of the most recent high reading. It assumes that the sensors
// are already synchronised to clk.
module sensor_scan_status #(
    parameter int unsigned NUM_SENSORS = scan_status_pkg::DEF_NUM_SENSORS,
    localparam int unsigned IDX_W = scan_status_pkg::span_width(NUM_SENSORS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_SENSORS-1:0] sensors,
    output logic [IDX_W-1:0]       scan_slot,
    output logic [IDX_W-1:0]       status_code
);
    // Frame sequencing
    scan_slot_counter #(.NUM_SENSORS(NUM_SENSORS)) u_slot (
        .clk   (clk),
        .rst_n (rst_n),
        .slot  (scan_slot)
    );

    // Latest-high status register
    scan_status_reg #(.NUM_SENSORS(NUM_SENSORS)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .slot    (scan_slot),
        .sensors (sensors),
        .status  (status_code)
    );
endmodule

// File: tb/sim_sensor_scan_status.sv
module sim_sensor_scan_status;
    localparam int N = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] sensors = '0;
    logic [2:0]   scan_slot;
    logic [2:0]   status_code;

    int compared = 0;
    int mismatched = 0;

    // Model state: the values expected after the next rising edge
    int    exp_slot = 0;
    int    exp_stat = 0;
    string slot_tag = "R1";
    string stat_tag = "R1";
    bit    have_exp = 1'b0;

    sensor_scan_status #(.NUM_SENSORS(N)) u0 (
        .clk(clk), .rst_n(rst_n), .sensors(sensors),
        .scan_slot(scan_slot), .status_code(status_code)
    );

    always #10 clk = ~clk;   // 50 MHz

    // Next slot as the requirements state it (R1, R2, R3)
    function automatic int next_slot(input bit r, input int s);
        if (!r) return 0;
        return (s == N) ? 0 : s + 1;
    endfunction

    // Next status as the requirements state it (R1, R4 to R7)
    function automatic int next_stat(input bit r, input int s, input int st, input logic [N-1:0] v);
        if (!r) return 0;
        if (s < N && v[s]) return s + 1;
        return st;
    endfunction

    task automatic compare(input string tag, input string what, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // One cycle: check the previous prediction, drive new inputs, predict the next values
    task automatic step(input bit r, input logic [N-1:0] v);
        int s;
        @(negedge clk);
        if (have_exp) begin
            compare(slot_tag, "scan_slot", int'(scan_slot), exp_slot);
            compare(stat_tag, "status_code", int'(status_code), exp_stat);
        end
        rst_n = r;
        sensors = v;
        s = exp_slot;
        if (!r) begin
            slot_tag = "R1";
            stat_tag = "R1";
        end else begin
            slot_tag = (s == N) ? "R3" : "R2";
            if (s == N)
                stat_tag = "R6";
            else if (v[s])
                stat_tag = "R4";
            else if (v != '0)
                stat_tag = "R7";
            else
                stat_tag = "R5";
        end
        exp_stat = next_stat(r, s, exp_stat, v);
        exp_slot = next_slot(r, s);
        have_exp = 1'b1;
    endtask

    // Watchdog
    initial begin
        #(20 * 150000);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        // R1: reset state
        step(1'b0, '1);
        step(1'b0, '1);
        // R4: all sensors high, so the code follows each slot; R6 holds code 5 in the idle slot
        for (int i = 0; i < 12; i++) step(1'b1, '1);
        // R4: front door high in slot 0, temperature high later, so the latest reading wins
        for (int i = 0; i < 6; i++) step(1'b1, (i == 0) ? 5'b00001 : (i == 4) ? 5'b10000 : 5'b00000);
        // R7: the examined bit is always low while the other bits are high
        for (int i = 0; i < 6; i++) step(1'b1, ~(5'b00001 << i));
        // R6: all bits high only in the idle slot
        for (int i = 0; i < 6; i++) step(1'b1, (i == 5) ? 5'b11111 : 5'b00000);
        // R1: reset in the middle of a frame
        step(1'b1, 5'b00100);
        step(1'b1, 5'b00100);
        step(1'b0, 5'b11111);
        for (int i = 0; i < 6; i++) step(1'b1, 5'b00000);
        // Random traffic with sparse sensors and rare resets
        for (int i = 0; i < 3000; i++) begin
            logic [N-1:0] v;
            v = N'($urandom) & N'($urandom);
            step(($urandom % 97) != 0, v);
        end
        step(1'b1, '0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule